// File: doc/BRIEF.md
# Two-Block-Ahead Branch Target Buffer

This block is a set-associative branch target buffer that looks one block further ahead than a conventional one. A lookup is keyed by the block fetched before the current one. The key has three parts: that block's line address, the slot of the instruction through which control left it, and a 2-bit class describing how control passed from it into the current block. A hit describes the branch that ends the current block: its slot in the line, its type and its stored target. The block combines that entry with an externally supplied taken/not-taken bit and the top of an external return-address stack. From these it forms the start address of the block that follows the current one, which is two blocks after the lookup key.

The front end keeps the caller's side of the contract. When a block has no branch, the caller supplies its last slot as the exit slot. Allocation is requested only after a taken branch was mispredicted or misfetched. An allocation names the same key form as a lookup and writes it with the branch's slot, type and target. A matching key is refreshed in place. Otherwise a free way is filled, or a pseudo-random way is replaced. Lookups are combinational against the stored entries. Allocations are written at the clock edge and are visible to lookups from the following cycle.

Top module: `ahead_btb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports no hit and returns the sequential line address.
- R2: On a miss the next address is the current line plus one with slot 0 ({lk_cur_line+1, 0}); when the line is all ones it wraps to zero.
- R3: The key covers the predecessor line, the exit slot and the transition class (0 = fall-through or no branch, 1 = taken non-return, 2 = return). The same line with a different exit slot or a different class misses.
- R4: The low log2(SETS) bits of the predecessor line pick the set. Lines that differ only in the higher bits share a set, are held as separate entries and both hit.
- R5: On a hit the block reports the stored branch slot and the stored type (0 = conditional, 1 = unconditional, 2 = indirect, 3 = return).
- R6: For a hit of type unconditional or indirect, the next address is the stored target.
- R7: For a conditional hit, the next address is the stored target when lk_taken is 1. Otherwise it is {lk_cur_line, branch slot} + 1, so slot 15 carries into slot 0 of the next line.
- R8: For a return hit, the next address is ras_top.
- R9: An allocation writes only in a cycle where al_valid is 1, and the entry answers lookups from the next cycle on.
- R10: Allocating a key that is already stored overwrites that way. The other entries in the set survive, and each key is held at most once.
- R11: While a set has an invalid way, allocation fills an invalid way, so four distinct keys in one 4-way set all remain.
- R12: Allocating a new key into a full set replaces exactly one existing entry, chosen by a free-running LFSR, and the new key hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pred_line | input | LINE_W | Line address of the predecessor block |
| lk_exit_slot | input | SLOT_W | Slot of the predecessor's exit instruction |
| lk_xclass | input | 2 | Transition class predecessor to current block |
| lk_cur_line | input | LINE_W | Line address of the current block |
| lk_taken | input | 1 | External outcome prediction for a conditional branch |
| ras_top | input | LINE_W+SLOT_W | Top of the return-address stack |
| lk_hit | output | 1 | Lookup hit |
| lk_br_slot | output | SLOT_W | Slot of the branch in the current block |
| lk_br_type | output | 2 | Type of that branch |
| lk_next | output | LINE_W+SLOT_W | Predicted start address two blocks ahead |
| al_valid | input | 1 | Allocate request |
| al_pred_line | input | LINE_W | Allocate key: predecessor line |
| al_exit_slot | input | SLOT_W | Allocate key: exit slot |
| al_xclass | input | 2 | Allocate key: transition class |
| al_br_slot | input | SLOT_W | Branch slot to store |
| al_br_type | input | 2 | Branch type to store |
| al_target | input | LINE_W+SLOT_W | Branch target to store |

## Verification
Lookups are run with each branch type, and conditional entries are tried with both outcome bits. This separates the target path, the slot-plus-one path and the stack-top path, and the not-taken case at slot 15 shows whether the carry crosses into the next line. Keys are varied one field at a time: the exit slot, the class, and the high line bits within a single set. These cases show whether every key field reaches the tag and whether the index takes only the low bits. A single set is filled, refreshed and then overfilled. This tells in-place overwrite apart from duplicate allocation, and free-way filling apart from premature eviction. Holding the allocate fields with the request low shows that nothing is written without it.

// File: rtl/ahead_btb_pkg.sv
package ahead_btb_pkg;
    typedef enum logic [1:0] {
        BT_COND  = 2'd0,
        BT_JUMP  = 2'd1,
        BT_INDIR = 2'd2,
        BT_RET   = 2'd3
    } br_type_e;

    typedef enum logic [1:0] {
        XC_FALL  = 2'd0,
        XC_TAKEN = 2'd1,
        XC_RET   = 2'd2,
        XC_RSVD  = 2'd3
    } xclass_e;
endpackage

// File: rtl/ahead_btb_match.sv
module ahead_btb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 30
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           key_tag,
    output logic [WAYS-1:0]            match
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = way_valid[w] && (way_tag[w] == key_tag);
    end
endmodule

// File: rtl/ahead_btb_victim.sv
module ahead_btb_victim #(
    parameter int WAYS   = 4,
    parameter int LFSR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WAYS-1:0] way_valid,
    input  logic [WAYS-1:0] match,
    output logic [WAYS-1:0] victim
);
    localparam int WAY_W = $clog2(WAYS);

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    // free-running Fibonacci LFSR, taps 16,14,13,11
    always_comb begin
        lfsr_d = {lfsr_q[LFSR_W-2:0],
                  lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-3] ^ lfsr_q[LFSR_W-4] ^ lfsr_q[LFSR_W-6]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= LFSR_W'(16'hACE1);
        else        lfsr_q <= lfsr_d;
    end

    // priority: existing match, then lowest invalid way, then random way
    always_comb begin
        victim = '0;
        victim[lfsr_q[WAY_W-1:0]] = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                victim    = '0;
                victim[w] = 1'b1;
            end
        end
        if (|match) victim = match;
    end
endmodule

// File: rtl/ahead_btb_nextaddr.sv
module ahead_btb_nextaddr
    import ahead_btb_pkg::*;
#(
    parameter int LINE_W = 28,
    parameter int SLOT_W = 4
) (
    input  logic                     hit,
    input  logic [1:0]               br_type,
    input  logic [SLOT_W-1:0]        br_slot,
    input  logic [LINE_W+SLOT_W-1:0] target,
    input  logic                     taken,
    input  logic [LINE_W-1:0]        cur_line,
    input  logic [LINE_W+SLOT_W-1:0] ras_top,
    output logic [LINE_W+SLOT_W-1:0] next_addr
);
    localparam int IA_W = LINE_W + SLOT_W;

    logic [IA_W-1:0] seq_addr;
    logic [IA_W-1:0] fall_addr;

    always_comb begin
        seq_addr  = {cur_line + LINE_W'(1), {SLOT_W{1'b0}}};
        fall_addr = {cur_line, br_slot} + IA_W'(1);
        if (!hit) begin
            next_addr = seq_addr;
        end else begin
            case (br_type)
                BT_COND:  next_addr = taken ? target : fall_addr;
                BT_RET:   next_addr = ras_top;
                default:  next_addr = target;
            endcase
        end
    end
endmodule

// File: rtl/ahead_btb.sv
module ahead_btb
    import ahead_btb_pkg::*;
#(
    parameter int LINE_W = 28,
    parameter int SLOT_W = 4,
    parameter int SETS   = 16,
    parameter int WAYS   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINE_W-1:0]        lk_pred_line,
    input  logic [SLOT_W-1:0]        lk_exit_slot,
    input  logic [1:0]               lk_xclass,
    input  logic [LINE_W-1:0]        lk_cur_line,
    input  logic                     lk_taken,
    input  logic [LINE_W+SLOT_W-1:0] ras_top,
    output logic                     lk_hit,
    output logic [SLOT_W-1:0]        lk_br_slot,
    output logic [1:0]               lk_br_type,
    output logic [LINE_W+SLOT_W-1:0] lk_next,
    input  logic                     al_valid,
    input  logic [LINE_W-1:0]        al_pred_line,
    input  logic [SLOT_W-1:0]        al_exit_slot,
    input  logic [1:0]               al_xclass,
    input  logic [SLOT_W-1:0]        al_br_slot,
    input  logic [1:0]               al_br_type,
    input  logic [LINE_W+SLOT_W-1:0] al_target
);
    localparam int IA_W  = LINE_W + SLOT_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = (LINE_W - IDX_W) + SLOT_W + 2;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SLOT_W-1:0] slot;
        logic [1:0]        btype;
        logic [IA_W-1:0]   target;
    } entry_t;

    typedef struct packed {
        logic   [SETS-1:0][WAYS-1:0] valid;
        entry_t [SETS-1:0][WAYS-1:0] ent;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0]            lk_set, al_set;
    logic [TAG_W-1:0]            lk_tag, al_tag;
    logic [WAYS-1:0][TAG_W-1:0]  lk_way_tag, al_way_tag;
    logic [WAYS-1:0]             hit_vec, al_match, victim_vec;
    entry_t                      rd_ent;

    assign lk_set = lk_pred_line[IDX_W-1:0];
    assign al_set = al_pred_line[IDX_W-1:0];
    assign lk_tag = {lk_pred_line[LINE_W-1:IDX_W], lk_exit_slot, lk_xclass};
    assign al_tag = {al_pred_line[LINE_W-1:IDX_W], al_exit_slot, al_xclass};

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_way_tag[w] = state_q.ent[lk_set][w].tag;
            al_way_tag[w] = state_q.ent[al_set][w].tag;
        end
    end

    ahead_btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .way_tag   (lk_way_tag),
        .way_valid (state_q.valid[lk_set]),
        .key_tag   (lk_tag),
        .match     (hit_vec)
    );

    ahead_btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_al_match (
        .way_tag   (al_way_tag),
        .way_valid (state_q.valid[al_set]),
        .key_tag   (al_tag),
        .match     (al_match)
    );

    ahead_btb_victim #(.WAYS(WAYS), .LFSR_W(16)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .way_valid (state_q.valid[al_set]),
        .match     (al_match),
        .victim    (victim_vec)
    );

    // read mux over the hitting way
    always_comb begin
        rd_ent = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) rd_ent = rd_ent | state_q.ent[lk_set][w];
        end
    end

    assign lk_hit     = |hit_vec;
    assign lk_br_slot = rd_ent.slot;
    assign lk_br_type = rd_ent.btype;

    ahead_btb_nextaddr #(.LINE_W(LINE_W), .SLOT_W(SLOT_W)) u_next (
        .hit       (lk_hit),
        .br_type   (rd_ent.btype),
        .br_slot   (rd_ent.slot),
        .target    (rd_ent.target),
        .taken     (lk_taken),
        .cur_line  (lk_cur_line),
        .ras_top   (ras_top),
        .next_addr (lk_next)
    );

    always_comb begin
        state_d = state_q;
        if (al_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (victim_vec[w]) begin
                    state_d.valid[al_set][w]      = 1'b1;
                    state_d.ent[al_set][w].tag    = al_tag;
                    state_d.ent[al_set][w].slot   = al_br_slot;
                    state_d.ent[al_set][w].btype  = al_br_type;
                    state_d.ent[al_set][w].target = al_target;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/ahead_btb_chk.sv
module ahead_btb_chk
    import ahead_btb_pkg::*;
#(
    parameter int LINE_W = 28,
    parameter int SLOT_W = 4,
    parameter int WAYS   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [LINE_W-1:0]        lk_pred_line,
    input logic [SLOT_W-1:0]        lk_exit_slot,
    input logic [1:0]               lk_xclass,
    input logic [LINE_W-1:0]        lk_cur_line,
    input logic                     lk_taken,
    input logic [LINE_W+SLOT_W-1:0] ras_top,
    input logic                     lk_hit,
    input logic [SLOT_W-1:0]        lk_br_slot,
    input logic [1:0]               lk_br_type,
    input logic [LINE_W+SLOT_W-1:0] lk_next,
    input logic                     al_valid,
    input logic [LINE_W-1:0]        al_pred_line,
    input logic [SLOT_W-1:0]        al_exit_slot,
    input logic [1:0]               al_xclass,
    input logic [SLOT_W-1:0]        al_br_slot,
    input logic [1:0]               al_br_type,
    input logic [WAYS-1:0]          hit_vec,
    input logic [WAYS-1:0]          victim_vec
);
    localparam int IA_W = LINE_W + SLOT_W;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R10

    AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        al_valid |-> $onehot(victim_vec)); // R11

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_next == {lk_cur_line + LINE_W'(1), {SLOT_W{1'b0}}}); // R2

    AST_RETURN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_br_type == BT_RET) |-> lk_next == ras_top); // R8

    AST_COND_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_br_type == BT_COND && !lk_taken)
        |-> lk_next == ({lk_cur_line, lk_br_slot} + IA_W'(1))); // R7

    AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(al_valid) && lk_pred_line == $past(al_pred_line)
         && lk_exit_slot == $past(al_exit_slot) && lk_xclass == $past(al_xclass))
        |-> (lk_hit && lk_br_slot == $past(al_br_slot)
             && lk_br_type == $past(al_br_type))); // R9
endmodule

bind ahead_btb ahead_btb_chk #(.LINE_W(LINE_W), .SLOT_W(SLOT_W), .WAYS(WAYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pred_line (lk_pred_line),
    .lk_exit_slot (lk_exit_slot),
    .lk_xclass    (lk_xclass),
    .lk_cur_line  (lk_cur_line),
    .lk_taken     (lk_taken),
    .ras_top      (ras_top),
    .lk_hit       (lk_hit),
    .lk_br_slot   (lk_br_slot),
    .lk_br_type   (lk_br_type),
    .lk_next      (lk_next),
    .al_valid     (al_valid),
    .al_pred_line (al_pred_line),
    .al_exit_slot (al_exit_slot),
    .al_xclass    (al_xclass),
    .al_br_slot   (al_br_slot),
    .al_br_type   (al_br_type),
    .hit_vec      (hit_vec),
    .victim_vec   (victim_vec)
);

// File: tb/ahead_btb_test.sv
module ahead_btb_test;
    localparam int LW = 28;
    localparam int SW = 4;
    localparam int IW = LW + SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] lk_pred_line = '0;
    logic [SW-1:0] lk_exit_slot = '0;
    logic [1:0]    lk_xclass = '0;
    logic [LW-1:0] lk_cur_line = '0;
    logic          lk_taken = 1'b0;
    logic [IW-1:0] ras_top = '0;
    logic          lk_hit;
    logic [SW-1:0] lk_br_slot;
    logic [1:0]    lk_br_type;
    logic [IW-1:0] lk_next;
    logic          al_valid = 1'b0;
    logic [LW-1:0] al_pred_line = '0;
    logic [SW-1:0] al_exit_slot = '0;
    logic [1:0]    al_xclass = '0;
    logic [SW-1:0] al_br_slot = '0;
    logic [1:0]    al_br_type = '0;
    logic [IW-1:0] al_target = '0;

    ahead_btb uut (.*);

    always #5 clk = ~clk;

    typedef struct {
        bit            hit;
        logic [SW-1:0] slot;
        logic [1:0]    btype;
        logic [IW-1:0] nxt;
        string         req;
    } item_t;

    item_t sbq[$];
    int checks = 0;
    int fails  = 0;

    localparam logic [LW-1:0] CUR = 28'h0001000;

    task automatic check(bit ok, string req, string what, logic [IW-1:0] act, logic [IW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: present a lookup, queue its expected result
    task automatic look(logic [LW-1:0] ln, logic [SW-1:0] sl, logic [1:0] xc,
                        logic [LW-1:0] cur, bit tk, bit eh, logic [SW-1:0] es,
                        logic [1:0] et, logic [IW-1:0] en, string req);
        item_t it;
        @(negedge clk);
        lk_pred_line = ln; lk_exit_slot = sl; lk_xclass = xc;
        lk_cur_line = cur; lk_taken = tk;
        it.hit = eh; it.slot = es; it.btype = et; it.nxt = en; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic alloc(logic [LW-1:0] ln, logic [SW-1:0] sl, logic [1:0] xc,
                         logic [SW-1:0] bs, logic [1:0] bt, logic [IW-1:0] tg);
        @(negedge clk);
        al_pred_line = ln; al_exit_slot = sl; al_xclass = xc;
        al_br_slot = bs; al_br_type = bt; al_target = tg;
        al_valid = 1'b1;
        @(negedge clk);
        al_valid = 1'b0;
    endtask

    task automatic probe(logic [LW-1:0] ln, logic [SW-1:0] sl, logic [1:0] xc, output bit h);
        @(negedge clk);
        lk_pred_line = ln; lk_exit_slot = sl; lk_xclass = xc;
        #3;
        h = lk_hit;
    endtask

    // monitor: pop and compare away from the clock edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #3;
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                check(lk_hit == it.hit, it.req, "hit", IW'(lk_hit), IW'(it.hit));
                if (it.hit) begin
                    check(lk_br_slot == it.slot, it.req, "slot", IW'(lk_br_slot), IW'(it.slot));
                    check(lk_br_type == it.btype, it.req, "type", IW'(lk_br_type), IW'(it.btype));
                end
                check(lk_next == it.nxt, it.req, "next", lk_next, it.nxt);
            end
        end
    end

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [LW-1:0] LA = 28'h0000013;
    localparam logic [LW-1:0] LB = 28'h0000023;
    localparam logic [LW-1:0] LC = 28'h0000033;
    localparam logic [LW-1:0] LD = 28'h0000043;
    localparam logic [LW-1:0] LE = 28'h0000053;

    initial begin
        bit h, ha, hb, hc, hd, he;
        int cnt;
        ras_top = 32'h00CAFE40;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(LA, 4'd7, 2'd1, CUR, 1'b1, 0, 0, 0, 32'h00010010, "R1");
        look(LB, 4'd0, 2'd0, CUR, 1'b0, 0, 0, 0, 32'h00010010, "R1");

        // A: conditional at slot 4
        alloc(LA, 4'd7, 2'd1, 4'd4, 2'd0, 32'h00ABCDE0);
        look(LA, 4'd7, 2'd1, CUR, 1'b1, 1, 4'd4, 2'd0, 32'h00ABCDE0, "R5");
        look(LA, 4'd7, 2'd1, CUR, 1'b1, 1, 4'd4, 2'd0, 32'h00ABCDE0, "R7");
        look(LA, 4'd7, 2'd1, CUR, 1'b0, 1, 4'd4, 2'd0, 32'h00010005, "R7");

        // R3: other exit slot / other class miss
        look(LA, 4'd7, 2'd0, CUR, 1'b1, 0, 0, 0, 32'h00010010, "R3");
        look(LA, 4'd6, 2'd1, CUR, 1'b1, 0, 0, 0, 32'h00010010, "R3");
        look(LA, 4'd7, 2'd2, CUR, 1'b1, 0, 0, 0, 32'h00010010, "R3");

        // B: same set, other high bits, unconditional
        alloc(LB, 4'd7, 2'd1, 4'd9, 2'd1, 32'h01234560);
        look(LB, 4'd7, 2'd1, CUR, 1'b0, 1, 4'd9, 2'd1, 32'h01234560, "R6");
        look(LA, 4'd7, 2'd1, CUR, 1'b1, 1, 4'd4, 2'd0, 32'h00ABCDE0, "R4");
        look(LB, 4'd7, 2'd1, CUR, 1'b1, 1, 4'd9, 2'd1, 32'h01234560, "R4");

        // C: return entry under return class
        alloc(LC, 4'd2, 2'd2, 4'd11, 2'd3, 32'h0);
        look(LC, 4'd2, 2'd2, CUR, 1'b0, 1, 4'd11, 2'd3, 32'h00CAFE40, "R8");

        // D: conditional at the last slot, fall-through crosses the line
        alloc(LD, 4'd15, 2'd0, 4'd15, 2'd0, 32'h00077770);
        look(LD, 4'd15, 2'd0, CUR, 1'b0, 1, 4'd15, 2'd0, 32'h00010010, "R7");

        // R11: all four stay
        probe(LA, 4'd7, 2'd1, ha); probe(LB, 4'd7, 2'd1, hb);
        probe(LC, 4'd2, 2'd2, hc); probe(LD, 4'd15, 2'd0, hd);
        check(ha && hb && hc && hd, "R11", "four-way fill", IW'({ha, hb, hc, hd}), IW'(4'hF));

        // R10: refresh B in place as indirect
        alloc(LB, 4'd7, 2'd1, 4'd3, 2'd2, 32'h00FEED00);
        look(LB, 4'd7, 2'd1, CUR, 1'b1, 1, 4'd3, 2'd2, 32'h00FEED00, "R6");
        probe(LA, 4'd7, 2'd1, ha); probe(LB, 4'd7, 2'd1, hb);
        probe(LC, 4'd2, 2'd2, hc); probe(LD, 4'd15, 2'd0, hd);
        check(ha && hb && hc && hd, "R10", "overwrite kept set", IW'({ha, hb, hc, hd}), IW'(4'hF));

        // R9: fields present without request do nothing
        @(negedge clk);
        al_pred_line = LE; al_exit_slot = 4'd1; al_xclass = 2'd1;
        al_br_slot = 4'd8; al_br_type = 2'd1; al_target = 32'h00BEEF00;
        @(negedge clk);
        look(LE, 4'd1, 2'd1, CUR, 1'b0, 0, 0, 0, 32'h00010010, "R9");

        // R12: fifth key evicts exactly one
        alloc(LE, 4'd1, 2'd1, 4'd8, 2'd1, 32'h00BEEF00);
        look(LE, 4'd1, 2'd1, CUR, 1'b0, 1, 4'd8, 2'd1, 32'h00BEEF00, "R9");
        probe(LE, 4'd1, 2'd1, he);
        probe(LA, 4'd7, 2'd1, ha); probe(LB, 4'd7, 2'd1, hb);
        probe(LC, 4'd2, 2'd2, hc); probe(LD, 4'd15, 2'd0, hd);
        cnt = int'(ha) + int'(hb) + int'(hc) + int'(hd);
        check(he, "R12", "new key", IW'(he), IW'(1));
        check(cnt == 3, "R12", "survivors", IW'(cnt), IW'(3));

        // R2: miss in another set with wrapping line
        look(28'h0000015, 4'd7, 2'd1, 28'hFFFFFFF, 1'b1, 0, 0, 0, 32'h00000000, "R2");
        look(28'h0000015, 4'd7, 2'd1, CUR, 1'b0, 0, 0, 0, 32'h00010010, "R2");

        repeat (3) @(negedge clk);
        h = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule